// File: doc/BRIEF.md
# Option-Configurable Parallel Read-Only Memory Port

This block is a clock-sampled model of an asynchronous, byte-wide read-only memory. It has a 19-bit address input and an 8-bit data output, and it stands in for a memory chip in a larger synchronous model. The contents are fixed when the block is built. They come from a closed-form function of the address and a seed parameter, so no storage array is needed.

Two control pins steer the block. Build-time parameters decide what each pin means. The first pin is either a chip select or an extra output enable, and either one may be active high or active low. The second pin is an output enable, active high or active low, or it is left unused. From the decoded enables the block picks one of three modes. In read mode it drives data. In deselect mode the outputs float. In standby the outputs float and a low-power indicator is raised.

Instead of an analog tri-state bus, the block gives a data value, a drive flag and a validity flag. Access, hold and turn-off delays are whole numbers of clock cycles. Each delay restarts when its own input changes.

Top module: `cfg_rom_port`

## Requirements
- R1: In read mode, with the access complete, `data_out` equals the stored byte for `addr`. With A as the address, the stored byte is (((A mod 256) * 37) mod 256) XOR ((A >> 8) mod 256) XOR ((A >> 16) mod 256) XOR `SEED`, and `SEED` defaults to 8'h5A.
- R2: `CTL1_MODE` selects the role of `ctl1_pin`: `C1_CE_HIGH` (chip select, active high), `C1_CE_LOW` (chip select, active low), `C1_OE_HIGH` (extra output enable, active high) or `C1_OE_LOW` (extra output enable, active low). `CTL2_MODE` selects the role of `ctl2_pin`: `C2_OE_HIGH`, `C2_OE_LOW` or `C2_NONE`.
- R3: Read mode holds exactly when the chip select and the combined output enable are both asserted. While read mode is sampled, `data_oe` is 1 from the first cycle. In deselect mode (chip select asserted, output enable not asserted), once settled, `data_oe`, `data_valid` and `standby` are all 0.
- R4: While the chip select is sampled deasserted, `standby` is 1 and `data_valid` is 0, whatever the output enable does. Once settled, `data_oe` is also 0.
- R5: Suppose both enables are held asserted and a new address is sampled at clock edge E. Then `data_valid` becomes 1 with the new byte in the cycle after edge E+`T_AA` (default 6).
- R6: Suppose the chip select is first sampled asserted at edge E, while the output enable and the address are steady. Then `data_valid` becomes 1 in the cycle after edge E+`T_ACE` (default 6). If the address changes at the same edge, the later of the two delays applies.
- R7: Suppose the output enable is first sampled asserted at edge E, while the chip select and the address are steady. Then `data_valid` becomes 1 in the cycle after edge E+`T_AOE` (default 4).
- R8: After an address change during a completed read, `data_valid` stays 1 with the previous byte for `T_OH` cycles (default 1). It then drops to 0 until the new access completes.
- R9: When read mode ends, `data_valid` drops to 0 in the first cycle. `data_oe` stays 1 for exactly `T_OD` cycles (default 3) and is 0 after that.
- R10: `data_out` is 0 in every cycle in which `data_valid` is 0.
- R11: With `C1_OE_*`, the chip select counts as always asserted, so `standby` is never 1. With `C2_NONE`, the level on `ctl2_pin` has no effect.
- R12: While reset is asserted, `data_oe`, `data_valid` and `data_out` are 0. `standby` is 1 if `ctl1_pin` is a chip select and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Model clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Byte address |
| ctl1_pin | input | 1 | First control pin; its role is set by `CTL1_MODE` |
| ctl2_pin | input | 1 | Second control pin; its role is set by `CTL2_MODE` |
| data_out | output | 8 | Byte read, 0 when not valid |
| data_oe | output | 1 | Drive flag; 0 means the bus floats |
| data_valid | output | 1 | The byte on `data_out` is good |
| standby | output | 1 | Low-power mode indicator |

## Verification
The contents are tested with several address patterns: walking ones and walking zeros across all 19 bits, a run of consecutive low addresses, and a large-stride scatter. The walking patterns show whether each address bit reaches the right byte slice of the function. The consecutive run exercises the multiply term, and the scatter reaches the upper slices. Latencies are measured one enable at a time from standby, from deselect and from an address step, so that each of the three delay paths can be told apart from the others. A second sweep drives every combination of control levels into all twelve option builds. This separates the pin roles and polarities, and it shows that an unused second pin is ignored.

// File: rtl/cfg_rom_pkg.sv
package cfg_rom_pkg;

  localparam int DATA_W = 8;

  typedef enum logic [1:0] {
    C1_CE_HIGH = 2'd0,
    C1_CE_LOW  = 2'd1,
    C1_OE_HIGH = 2'd2,
    C1_OE_LOW  = 2'd3
  } ctl1_mode_e;

  typedef enum logic [1:0] {
    C2_OE_HIGH = 2'd0,
    C2_OE_LOW  = 2'd1,
    C2_NONE    = 2'd2
  } ctl2_mode_e;

  // Fixed contents: byte derived arithmetically from the address.
  function automatic logic [DATA_W-1:0] rom_byte(input logic [31:0] a,
                                                 input logic [DATA_W-1:0] seed);
    logic [DATA_W-1:0] mix;
    mix = a[7:0] * 8'd37;
    return mix ^ a[15:8] ^ a[23:16] ^ a[31:24] ^ seed;
  endfunction

endpackage

// File: rtl/cfg_rom_decode.sv
module cfg_rom_decode
  import cfg_rom_pkg::*;
#(
  parameter ctl1_mode_e CTL1_MODE = C1_CE_LOW,
  parameter ctl2_mode_e CTL2_MODE = C2_OE_LOW
) (
  input  logic ctl1_pin,
  input  logic ctl2_pin,
  output logic ce_act,
  output logic oe_act
);

  localparam logic C1_IS_CE = (CTL1_MODE == C1_CE_HIGH) || (CTL1_MODE == C1_CE_LOW);
  localparam logic C1_INV   = (CTL1_MODE == C1_CE_LOW)  || (CTL1_MODE == C1_OE_LOW);
  localparam logic C2_USED  = (CTL2_MODE != C2_NONE);
  localparam logic C2_INV   = (CTL2_MODE == C2_OE_LOW);

  logic c1_on;
  logic c2_on;

  always_comb begin
    c1_on  = ctl1_pin ^ C1_INV;
    c2_on  = C2_USED ? (ctl2_pin ^ C2_INV) : 1'b1;
    ce_act = C1_IS_CE ? c1_on : 1'b1;
    oe_act = (C1_IS_CE ? 1'b1 : c1_on) & c2_on;
  end

endmodule

// File: rtl/cfg_rom_age.sv
module cfg_rom_age #(
  parameter int AGE_W = 4,
  parameter int CAP   = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  output logic [AGE_W-1:0] age
);

  logic [AGE_W-1:0] age_d;

  always_comb begin
    if (clear)                      age_d = '0;
    else if (age >= AGE_W'(CAP))    age_d = age;
    else                            age_d = age + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age <= '0;
    else        age <= age_d;
  end

endmodule

// File: rtl/cfg_rom_drive.sv
module cfg_rom_drive #(
  parameter int DATA_W = 8,
  parameter int T_OD   = 3,
  parameter int T_OH   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_done,
  input  logic              read_q,
  input  logic              read_d,
  input  logic [DATA_W-1:0] word_in,
  output logic [DATA_W-1:0] data_out,
  output logic              data_oe,
  output logic              data_valid
);

  localparam int HOLD_W = $clog2(T_OH + 2);
  localparam int OFF_W  = $clog2(T_OD + 2);

  logic [HOLD_W-1:0] hold_left, hold_left_d;
  logic [OFF_W-1:0]  off_left,  off_left_d;
  logic [DATA_W-1:0] last_word, last_word_d;

  always_comb begin
    last_word_d = last_word;
    hold_left_d = hold_left;
    if (acc_done) begin
      last_word_d = word_in;
      hold_left_d = HOLD_W'(T_OH);
    end else if (hold_left != '0) begin
      hold_left_d = hold_left - 1'b1;
    end
    if (!read_d) hold_left_d = '0;

    if (read_q)               off_left_d = OFF_W'(T_OD);
    else if (off_left != '0)  off_left_d = off_left - 1'b1;
    else                      off_left_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_left <= '0;
      off_left  <= '0;
      last_word <= '0;
    end else begin
      hold_left <= hold_left_d;
      off_left  <= off_left_d;
      last_word <= last_word_d;
    end
  end

  always_comb begin
    data_valid = read_q & (acc_done | (hold_left != '0));
    data_oe    = read_q | (off_left != '0);
    if (acc_done)        data_out = word_in;
    else if (data_valid) data_out = last_word;
    else                 data_out = '0;
  end

endmodule

// File: rtl/cfg_rom_port.sv
module cfg_rom_port
  import cfg_rom_pkg::*;
#(
  parameter ctl1_mode_e       CTL1_MODE = C1_CE_LOW,
  parameter ctl2_mode_e       CTL2_MODE = C2_OE_LOW,
  parameter int               ADDR_W    = 19,
  parameter int               T_AA      = 6,
  parameter int               T_ACE     = 6,
  parameter int               T_AOE     = 4,
  parameter int               T_OD      = 3,
  parameter int               T_OH      = 1,
  parameter logic [DATA_W-1:0] SEED     = 8'h5A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ctl1_pin,
  input  logic              ctl2_pin,
  output logic [DATA_W-1:0] data_out,
  output logic              data_oe,
  output logic              data_valid,
  output logic              standby
);

  localparam int   LAT_AC  = (T_AA > T_ACE) ? T_AA : T_ACE;
  localparam int   LAT_MAX = (LAT_AC > T_AOE) ? LAT_AC : T_AOE;
  localparam int   AGE_W   = $clog2(LAT_MAX + 2);
  localparam int   IDLE_W  = $clog2(T_OD + 2);
  localparam logic CE_USED = (CTL1_MODE == C1_CE_HIGH) || (CTL1_MODE == C1_CE_LOW);

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_pipe;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ni = rst_pipe[1];

  // Control decode.
  logic ce_act, oe_act;

  cfg_rom_decode #(
    .CTL1_MODE (CTL1_MODE),
    .CTL2_MODE (CTL2_MODE)
  ) u_decode (
    .ctl1_pin (ctl1_pin),
    .ctl2_pin (ctl2_pin),
    .ce_act   (ce_act),
    .oe_act   (oe_act)
  );

  // Input sampling.
  logic [ADDR_W-1:0] addr_q;
  logic              ce_q, oe_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      ce_q   <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      addr_q <= addr;
      ce_q   <= ce_act;
      oe_q   <= oe_act;
    end
  end

  // Latency ages, one per input path.
  logic [AGE_W-1:0] addr_age, ce_age, oe_age;
  logic             addr_clr, ce_clr, oe_clr;

  always_comb begin
    addr_clr = (addr != addr_q);
    ce_clr   = !(ce_act & ce_q);
    oe_clr   = !(oe_act & oe_q);
  end

  cfg_rom_age #(.AGE_W(AGE_W), .CAP(LAT_MAX)) u_age_addr (
    .clk (clk), .rst_n (rst_ni), .clear (addr_clr), .age (addr_age)
  );
  cfg_rom_age #(.AGE_W(AGE_W), .CAP(LAT_MAX)) u_age_ce (
    .clk (clk), .rst_n (rst_ni), .clear (ce_clr), .age (ce_age)
  );
  cfg_rom_age #(.AGE_W(AGE_W), .CAP(LAT_MAX)) u_age_oe (
    .clk (clk), .rst_n (rst_ni), .clear (oe_clr), .age (oe_age)
  );

  // Mode and access completion.
  logic              read_q, read_d, acc_done;
  logic [DATA_W-1:0] rom_word;

  always_comb begin
    read_q   = ce_q & oe_q;
    read_d   = ce_act & oe_act;
    acc_done = read_q
             & (addr_age >= AGE_W'(T_AA))
             & (ce_age   >= AGE_W'(T_ACE))
             & (oe_age   >= AGE_W'(T_AOE));
    rom_word = rom_byte(32'(addr_q), SEED);
  end

  cfg_rom_drive #(
    .DATA_W (DATA_W),
    .T_OD   (T_OD),
    .T_OH   (T_OH)
  ) u_drive (
    .clk        (clk),
    .rst_n      (rst_ni),
    .acc_done   (acc_done),
    .read_q     (read_q),
    .read_d     (read_d),
    .word_in    (rom_word),
    .data_out   (data_out),
    .data_oe    (data_oe),
    .data_valid (data_valid)
  );

  assign standby = CE_USED & !ce_q;

  // Checker state: cycles spent outside read mode.
  logic [IDLE_W-1:0] idle_run;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)                       idle_run <= '0;
    else if (read_q)                   idle_run <= '0;
    else if (idle_run < IDLE_W'(T_OD)) idle_run <= idle_run + 1'b1;
  end

  assert_valid_drives_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    data_valid |-> (data_oe && !standby));

  assert_standby_quiet_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    standby |-> !data_valid);

  assert_hold_old_byte_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    (!$stable(addr_q) && data_valid) |-> ($past(data_valid) && data_out == $past(data_out)));

  assert_disable_bound_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    (!read_q && idle_run >= IDLE_W'(T_OD)) |-> !data_oe);

  assert_zero_when_invalid_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    !data_valid |-> (data_out == '0));

endmodule

// File: tb/cfg_rom_port_bench.sv
module cfg_rom_port_bench;
  import cfg_rom_pkg::*;

  localparam int T_AA  = 6;
  localparam int T_ACE = 6;
  localparam int T_AOE = 4;
  localparam int T_OD  = 3;
  localparam int NCFG  = 12;

  logic        clk;
  logic        rst_n;
  logic [18:0] addr;
  logic        ce_n, oe_n;
  logic        a1, a2;
  logic [7:0]  data_out;
  logic        data_oe, data_valid, standby;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  cfg_rom_port u_cfg_rom_port (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr       (addr),
    .ctl1_pin   (ce_n),
    .ctl2_pin   (oe_n),
    .data_out   (data_out),
    .data_oe    (data_oe),
    .data_valid (data_valid),
    .standby    (standby)
  );

  wire [7:0] g_out   [NCFG];
  wire       g_oe    [NCFG];
  wire       g_valid [NCFG];
  wire       g_stby  [NCFG];

  for (genvar gi = 0; gi < NCFG; gi++) begin : g_cfg
    localparam ctl1_mode_e M1 = ctl1_mode_e'(gi / 3);
    localparam ctl2_mode_e M2 = ctl2_mode_e'(gi % 3);
    wire p1 = a1 ^ ((M1 == C1_CE_LOW) || (M1 == C1_OE_LOW));
    wire p2 = a2 ^ (M2 == C2_OE_LOW);
    cfg_rom_port #(.CTL1_MODE(M1), .CTL2_MODE(M2)) u_opt (
      .clk        (clk),
      .rst_n      (rst_n),
      .addr       (addr),
      .ctl1_pin   (p1),
      .ctl2_pin   (p2),
      .data_out   (g_out[gi]),
      .data_oe    (g_oe[gi]),
      .data_valid (g_valid[gi]),
      .standby    (g_stby[gi])
    );
  end

  function automatic logic [7:0] exp_byte(input int a);
    int m;
    m = ((a % 256) * 37) % 256;
    return 8'(m ^ ((a >> 8) % 256) ^ ((a >> 16) % 256) ^ 8'h5A);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic measure(output int lat, output logic oe0);
    lat = -1;
    oe0 = 1'b0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (i == 0) oe0 = data_oe;
      if (data_valid) begin
        lat = i;
        break;
      end
    end
  endtask

  task automatic probe(input int a);
    addr = 19'(a);
    repeat (T_AA + 1) @(negedge clk);
    chk("R1 valid", 32'(data_valid), 32'd1);
    chk("R1 byte", 32'(data_out), 32'(exp_byte(a)));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int   lat;
    logic oe0;
    int   old_a;
    rst_n = 1'b0; ce_n = 1'b1; oe_n = 1'b1; addr = '0; a1 = 1'b0; a2 = 1'b0;
    repeat (3) @(negedge clk);
    chk("R12 data_oe", 32'(data_oe), 32'd0);
    chk("R12 data_valid", 32'(data_valid), 32'd0);
    chk("R12 data_out", 32'(data_out), 32'd0);
    chk("R12 standby chip-select", 32'(standby), 32'd1);
    chk("R12 standby enable-only", 32'(g_stby[6]), 32'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R4: standby with the output enable asserted
    oe_n = 1'b0; addr = 19'h01234;
    repeat (10) @(negedge clk);
    chk("R4 standby", 32'(standby), 32'd1);
    chk("R4 data_oe", 32'(data_oe), 32'd0);
    chk("R4 data_valid", 32'(data_valid), 32'd0);

    // R6: chip-select latency; R3: drive starts at once
    ce_n = 1'b0;
    measure(lat, oe0);
    chk("R6 latency", 32'(lat), 32'(T_ACE));
    chk("R3 drive immediate", 32'(oe0), 32'd1);
    chk("R1 byte after select", 32'(data_out), 32'(exp_byte(32'h01234)));

    // R3: deselect
    oe_n = 1'b1;
    repeat (10) @(negedge clk);
    chk("R3 deselect standby", 32'(standby), 32'd0);
    chk("R3 deselect data_oe", 32'(data_oe), 32'd0);
    chk("R3 deselect data_valid", 32'(data_valid), 32'd0);
    chk("R10 deselect data_out", 32'(data_out), 32'd0);

    // R7: output-enable latency
    oe_n = 1'b0;
    measure(lat, oe0);
    chk("R7 latency", 32'(lat), 32'(T_AOE));

    // R9: turn-off window
    repeat (2) @(negedge clk);
    oe_n = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk("R9 data_oe window", 32'(data_oe), (i < T_OD) ? 32'd1 : 32'd0);
      chk("R9 data_valid drop", 32'(data_valid), 32'd0);
    end

    // R5 / R8 / R10: address step
    oe_n = 1'b0;
    repeat (10) @(negedge clk);
    old_a = int'(addr);
    addr = 19'h5A5A5;
    for (int i = 0; i <= T_AA; i++) begin
      @(negedge clk);
      if (i == 0) begin
        chk("R8 hold valid", 32'(data_valid), 32'd1);
        chk("R8 hold old byte", 32'(data_out), 32'(exp_byte(old_a)));
      end else if (i < T_AA) begin
        chk("R8 invalid after hold", 32'(data_valid), 32'd0);
        chk("R10 zero while invalid", 32'(data_out), 32'd0);
      end else begin
        chk("R5 valid at latency", 32'(data_valid), 32'd1);
        chk("R5 new byte", 32'(data_out), 32'(exp_byte(32'h5A5A5)));
      end
    end

    // R6: address and chip select change together
    ce_n = 1'b1;
    repeat (10) @(negedge clk);
    addr = 19'h7FFFF; ce_n = 1'b0;
    measure(lat, oe0);
    chk("R6 combined latency", 32'(lat), 32'(LAT_MAXB()));
    chk("R1 top address", 32'(data_out), 32'(exp_byte(32'h7FFFF)));

    // R1 sweeps
    for (int b = 0; b < 19; b++) probe(1 << b);
    for (int b = 0; b < 19; b++) probe(32'h7FFFF ^ (1 << b));
    for (int k = 0; k < 256; k++) probe(k);
    for (int k = 0; k < 512; k++) probe((k * 1021 + 77) % 524288);

    // R2 / R11: every option build, every control level
    addr = 19'h2B7C4;
    for (int v1 = 0; v1 < 2; v1++) begin
      for (int v2 = 0; v2 < 2; v2++) begin
        a1 = v1[0]; a2 = v2[0];
        repeat (12) @(negedge clk);
        for (int i = 0; i < NCFG; i++) begin
          bit is_ce, rd, sb;
          is_ce = (i / 3) < 2;
          rd    = v1[0] && ((i % 3) == 2 || v2[0]);
          sb    = is_ce && !v1[0];
          chk("R2 R11 option drive", 32'(g_oe[i]), 32'(rd));
          chk("R2 R11 option valid", 32'(g_valid[i]), 32'(rd));
          chk("R2 R11 option standby", 32'(g_stby[i]), 32'(sb));
          chk("R2 R11 option byte", 32'(g_out[i]), rd ? 32'(exp_byte(32'h2B7C4)) : 32'd0);
        end
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  function automatic int LAT_MAXB();
    return (T_AA > T_ACE) ? T_AA : T_ACE;
  endfunction

endmodule